// File: doc/BRIEF.md
# Time-Multiplexed Bit-Serial Lattice Filter

This block is the all-pole vocal-tract stage of a linear-predictive speech synthesizer. It runs a ten-stage lattice recursion in which every operand enters and leaves on a single wire, least significant bit first. One multiply-add unit is shared across the whole computation. A frame is 22 word slots of 24 clocks each, so a frame lasts 528 clocks. One output sample is produced per frame.

In word slot 0 the host sends a gain word and an excitation sample, and slots 0 and 1 form their scaled product. Each lattice stage then uses two consecutive slots, one per multiplication. Stage n reads its reflection coefficient in slot 2n+2. The first slot of a stage updates the forward value. The second slot updates the backward value that the neighbouring stage uses in the next frame. The finished sample is shifted out during slot 0 of the following frame.

The block drives a word strobe and a frame strobe, which a host uses to align its serial traffic. These strobes can also drive the sync input of a second instance so that both run in step. All pins are active low.

Top module: `lpc_lattice`

## Requirements
- R1: A frame is 22 words of 24 clocks. `lsbOutN` is low on bit 0 of every word and high on every other clock. `frameOutN` is low for all 24 clocks of word 0 and high in words 1 to 21.
- R2: Every data pin is active low. The logical bit is the inverse of the pin level, on `dataInN` and `excInN` going in and on `speechOutN` going out.
- R3: Serial words are two's complement, least significant bit first. Bit j of a word occupies clock j of its word slot.
- R4: In word 0 the 24-bit excitation is read from `excInN`, and the gain is read from bits 13..0 of `dataInN` as a signed fraction with 13 fractional bits. Bits 23..14 of any coefficient word are ignored, and `excInN` is ignored outside word 0.
- R5: Coefficient k_n (n = 0..9) is read from bits 13..0 of `dataInN` in word 2n+2, in the same fraction format. `dataInN` is ignored in words 1, 3, 5, ..., 21.
- R6: Every product is the full signed product shifted right by 13 with rounding toward minus infinity, then cut to its low 24 bits. Every sum and difference wraps modulo 2^24.
- R7: The recursion is as follows. Start with e = u*A and set f = e. For n = 0..9 in order: f <= f - k_n*b_n, then b_(n-1) <= b_n + k_n*f for n >= 1; the n = 0 backward result is discarded. After stage 9, b_9 <= f. The sample is y = f. Each b_n is the value stored by the previous frame, and all are zero after reset.
- R8: The sample y of a frame is emitted LSB first on `speechOutN` during word 0 of the next frame. The pin is high in words 1 to 21. Before the first frame completes, the emitted sample is zero.
- R9: While `rstN` is low, the word and bit position is bit 0 of word 0, the backward store is cleared, `lsbOutN` and `frameOutN` are low, and `speechOutN` is high.
- R10: If `syncInN` is low in a clock, the next clock is bit 0 of word 0. Otherwise the frame timing runs freely. A sync pulse on the last clock of word 21 leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncInN | input | 1 | Frame alignment pulse, active low |
| dataInN | input | 1 | Serial gain and coefficient words, active low |
| excInN | input | 1 | Serial excitation word, active low |
| speechOutN | output | 1 | Serial output sample, active low |
| lsbOutN | output | 1 | Word strobe, low on bit 0 of each word |
| frameOutN | output | 1 | Frame strobe, low during word 0 |

## Verification
Two things coincide on the last clock of word 21. The final backward update of stage 9 writes the store in the same clock that the finished sample is copied into the output shifter. An external sync pulse can arrive in that same clock as well. The bench puts a sync pulse exactly on that clock in one frame, and aborts another frame with a sync pulse inside word 0. In both cases it compares every pin on every clock against a behavioural parallel lattice, fed with random, zero and full-scale coefficients. The comparison must show that the sample stream and the backward history continue without a slip.

// File: rtl/lattice_pkg.sv
package lattice_pkg;
  localparam int DATA_W = 24;
  localparam int COEF_W = 14;
  localparam int FRAC_W = COEF_W - 1;
  localparam int STAGES = 10;
  localparam int WORDS  = 2 * STAGES + 2;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int WCNT_W = $clog2(WORDS);
  localparam int STG_W  = $clog2(STAGES);

  // Strobes from the slot sequencer to the shared arithmetic
  typedef struct packed {
    logic             coefShift;  // bits 0..COEF_W-1 of a word: coefficient shifter runs
    logic             capIn;      // end of word 0: latch gain and excitation
    logic             gain;       // end of word 1: excitation times gain
    logic             fwdStep;    // end of an even stage word: forward update
    logic             bwdStep;    // end of an odd stage word: backward update
    logic             lastStep;   // end of the final word: close the frame
    logic [STG_W-1:0] stage;      // stage served by the current word pair
  } ctrl_t;
endpackage

// File: rtl/lattice_ctrl.sv
module lattice_ctrl
  import lattice_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  syncReq,
  output ctrl_t ctl,
  output logic  lsbPulse,
  output logic  framePulse
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(WORDS - 1);

  logic [BIT_W-1:0]  bitCnt;
  logic [WCNT_W-1:0] wordCnt;
  logic              atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (syncReq) begin
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (atLast) begin
      bitCnt  <= '0;
      wordCnt <= (wordCnt == LAST_WORD) ? '0 : wordCnt + 1'b1;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    atLast        = (bitCnt == LAST_BIT);
    ctl.coefShift = (bitCnt < BIT_W'(COEF_W));
    ctl.capIn     = atLast && (wordCnt == '0);
    ctl.gain      = atLast && (wordCnt == WCNT_W'(1));
    ctl.fwdStep   = atLast && (wordCnt >= WCNT_W'(2)) && !wordCnt[0];
    ctl.bwdStep   = atLast && (wordCnt >= WCNT_W'(3)) && wordCnt[0];
    ctl.lastStep  = atLast && (wordCnt == LAST_WORD);
    ctl.stage     = STG_W'((wordCnt - WCNT_W'(2)) >> 1);
    lsbPulse      = (bitCnt == '0);
    framePulse    = (wordCnt == '0);
  end
endmodule

// File: rtl/lattice_dp.sv
module lattice_dp
  import lattice_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  ctrl_t ctl,
  input  logic  dataBit,
  input  logic  excBit,
  output logic  speechBit
);
  logic        [COEF_W-1:0] coefSr;
  logic        [DATA_W-2:0] excSr;
  logic signed [COEF_W-1:0] ampReg, kReg, opK;
  logic signed [DATA_W-1:0] excReg, fwdReg;
  logic signed [DATA_W-1:0] opA, base, mulOut, sum;
  logic signed [DATA_W+COEF_W-1:0] prod;
  logic        [DATA_W-1:0] outSr;
  logic        [DATA_W-1:0] bStore [STAGES];
  logic        [STAGES-2:0] wrEn;
  logic                     doSub;
  logic        [DATA_W-1:0] excWord;

  assign excWord = {excBit, excSr};

  // Serial capture: coefficient field is the low COEF_W bits of its word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefSr <= '0;
      excSr  <= '0;
    end else begin
      if (ctl.coefShift) coefSr <= {dataBit, coefSr[COEF_W-1:1]};
      excSr <= {excBit, excSr[DATA_W-2:1]};
    end
  end

  // Operand selection for the one shared multiply-add
  always_comb begin
    opA   = excReg;
    opK   = ampReg;
    base  = '0;
    doSub = 1'b0;
    if (ctl.fwdStep) begin
      opA   = bStore[ctl.stage];
      opK   = coefSr;
      base  = fwdReg;
      doSub = 1'b1;
    end else if (ctl.bwdStep) begin
      opA   = fwdReg;
      opK   = kReg;
      base  = bStore[ctl.stage];
    end
  end

  assign prod   = opA * opK;
  assign mulOut = DATA_W'(prod >>> FRAC_W);
  assign sum    = doSub ? (base - mulOut) : (base + mulOut);

  // One write enable per stored backward value, decoded from the stage index
  for (genvar g = 0; g < STAGES - 1; g++) begin : g_wr
    assign wrEn[g] = ctl.bwdStep && (ctl.stage == STG_W'(g + 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ampReg <= '0;
      kReg   <= '0;
      excReg <= '0;
      fwdReg <= '0;
      outSr  <= '0;
      for (int g = 0; g < STAGES; g++) bStore[g] <= '0;
    end else begin
      if (ctl.capIn) begin
        ampReg <= coefSr;
        excReg <= excWord;
      end
      if (ctl.gain) fwdReg <= sum;
      if (ctl.fwdStep) begin
        fwdReg <= sum;
        kReg   <= coefSr;
      end
      for (int g = 0; g < STAGES - 1; g++) begin
        if (wrEn[g]) bStore[g] <= sum;
      end
      if (ctl.lastStep) begin
        bStore[STAGES-1] <= fwdReg;
        outSr            <= fwdReg;
      end else begin
        outSr <= {1'b0, outSr[DATA_W-1:1]};
      end
    end
  end

  assign speechBit = outSr[0];
endmodule

// File: rtl/lpc_lattice.sv
module lpc_lattice
  import lattice_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic syncInN,
  input  logic dataInN,
  input  logic excInN,
  output logic speechOutN,
  output logic lsbOutN,
  output logic frameOutN
);
  ctrl_t ctl;
  logic  lsbPulse, framePulse, speechBit;

  lattice_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncReq   (!syncInN),
    .ctl       (ctl),
    .lsbPulse  (lsbPulse),
    .framePulse(framePulse)
  );

  lattice_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dataBit  (!dataInN),
    .excBit   (!excInN),
    .speechBit(speechBit)
  );

  assign speechOutN = !speechBit;
  assign lsbOutN    = !lsbPulse;
  assign frameOutN  = !framePulse;
endmodule

// File: rtl/lpc_lattice_chk.sv
module lpc_lattice_chk
  import lattice_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic syncInN,
  input logic speechOutN,
  input logic lsbOutN,
  input logic frameOutN
);
  logic [BIT_W:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= '0;
    else if (!lsbOutN) gap <= (BIT_W+1)'(1);
    else if (gap != '1) gap <= gap + 1'b1;
  end

  // R1
  lsb_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gap == (BIT_W+1)'(DATA_W)) |-> !lsbOutN);

  // R1
  lsb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lsbOutN && syncInN) |=> lsbOutN);

  // R1
  frame_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOutN) |-> !lsbOutN);

  // R1
  frame_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOutN) |-> !lsbOutN);

  // R8
  speech_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameOutN |-> speechOutN);

  // R10
  sync_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncInN |=> (!lsbOutN && !frameOutN));
endmodule

bind lpc_lattice lpc_lattice_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .syncInN   (syncInN),
  .speechOutN(speechOutN),
  .lsbOutN   (lsbOutN),
  .frameOutN (frameOutN)
);

// File: tb/test_lpc_lattice.sv
`timescale 1ns/1ps
module test_lpc_lattice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, syncInN, dataInN, excInN;
  logic speechOutN, lsbOutN, frameOutN;

  lpc_lattice i_lpc_lattice (
    .clk(clk), .rstN(rstN), .syncInN(syncInN), .dataInN(dataInN),
    .excInN(excInN), .speechOutN(speechOutN), .lsbOutN(lsbOutN),
    .frameOutN(frameOutN)
  );

  int     nChk = 0, nFail = 0;
  int     curW = 0, curB = 0;
  bit     finished = 0;
  longint bq[10];
  longint kv[10];
  longint yPrev;

  function automatic longint wrap24(longint x);
    longint t = x & 64'hFFFFFF;
    if (t >= 64'h800000) t = t - 64'h1000000;
    return t;
  endfunction

  // R6: floor shift by 13, keep low 24 bits
  function automatic longint mulT(longint a, longint k);
    return wrap24((a * k) >>> 13);
  endfunction

  // R7: parallel reference lattice, updates the backward history
  function automatic longint latticeStep(longint amp, longint u);
    longint f = mulT(u, amp);
    for (int n = 0; n < 10; n++) begin
      longint bn;
      f  = wrap24(f - mulT(bq[n], kv[n]));
      bn = wrap24(bq[n] + mulT(f, kv[n]));
      if (n > 0) bq[n-1] = bn;
    end
    bq[9] = f;
    return f;
  endfunction

  task automatic chk(string what, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at word %0d bit %0d: actual %b expected %b",
               what, curW, curB, act, exp);
    end
  endtask

  function automatic longint randCoef();
    return longint'($urandom_range(16382)) - 8191;
  endfunction

  // mode 0 random, 1 small excitation, 2 zero coefficients, 3 full scale, 4 zero gain
  task automatic runFrame(int mode, int abortAt, bit syncAtEnd, bit maskSpeech);
    logic [23:0] dw[22];
    logic [23:0] ew[22];
    longint amp, u;
    amp = randCoef();
    u   = wrap24(longint'($urandom));
    for (int n = 0; n < 10; n++) kv[n] = randCoef();
    case (mode)
      1: u = longint'($urandom_range(8191)) - 4096;
      2: for (int n = 0; n < 10; n++) kv[n] = 0;
      3: begin
        amp = 8191;
        u   = 64'h7FFFFF;
        for (int n = 0; n < 10; n++) kv[n] = n[0] ? -8191 : 8191;
      end
      4: amp = 0;
      default: ;
    endcase
    for (int w = 0; w < 22; w++) begin
      dw[w] = 24'($urandom);
      ew[w] = 24'($urandom);
    end
    dw[0][13:0] = amp[13:0];
    ew[0]       = u[23:0];
    for (int n = 0; n < 10; n++) dw[2*n+2][13:0] = kv[n][13:0];

    for (int w = 0; w < 22; w++) begin
      for (int b = 0; b < 24; b++) begin
        curW = w;
        curB = b;
        chk("R1 lsbOutN", lsbOutN, (b != 0));
        chk("R1 frameOutN", frameOutN, (w != 0));
        if (!(maskSpeech && w == 0))
          chk("R2/R3/R4/R5/R6/R7/R8 speechOutN", speechOutN,
              (w == 0) ? ~yPrev[b] : 1'b1);
        dataInN = ~dw[w][b];
        excInN  = ~ew[w][b];
        syncInN = !((w == 0 && b == abortAt) || (syncAtEnd && w == 21 && b == 23));
        @(negedge clk);
        if (w == 0 && b == abortAt) return;
      end
    end
    yPrev = latticeStep(amp, u);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R1 watchdog: actual no finish expected finish within 200000 cycles");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN    = 1'b0;
    syncInN = 1'b1;
    dataInN = 1'b1;
    excInN  = 1'b1;
    yPrev   = 0;
    for (int n = 0; n < 10; n++) bq[n] = 0;
    repeat (3) @(negedge clk);
    chk("R9 lsbOutN in reset", lsbOutN, 1'b0);
    chk("R9 frameOutN in reset", frameOutN, 1'b0);
    chk("R9 speechOutN in reset", speechOutN, 1'b1);
    rstN = 1'b1;

    for (int i = 0; i < 32; i++) begin
      if (i == 14) begin
        // R10: abort inside word 0, timing restarts on the next clock
        runFrame(0, 5, 1'b0, 1'b0);
        curW = 0;
        curB = 0;
        chk("R10 lsbOutN after sync", lsbOutN, 1'b0);
        chk("R10 frameOutN after sync", frameOutN, 1'b0);
        runFrame(0, -1, 1'b0, 1'b1);
      end else begin
        // R10: sync on the natural wrap leaves the timing unchanged
        runFrame(i % 5, -1, (i == 7), 1'b0);
      end
    end
    // R8: flush the last sample
    runFrame(2, -1, 1'b0, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule